// File: doc/BRIEF.md
# Serial Register Access Port

This block lets an external host read and write a bank of 16-bit control registers over a four-wire serial link. The serial clock idles low. The block samples input bits on the rising clock edge and changes its output on the falling edge. Bits travel most significant first. An active-low select frames each transaction.

The first byte is a header from the host. Its top bit picks the direction, and its low six bits give the starting register address. After the header come one or more 16-bit words. In a write the words come in from the host, and in a read they go out to it. Data never flows both ways in the same transaction. The address steps by one after each word, so a long transaction walks through consecutive registers.

The block runs entirely on a faster system clock. It passes the serial clock, data and select through two-stage synchronisers and detects their edges in that domain. On the register side it issues one-cycle read and write strobes, with an address and write data that the surrounding logic decodes. The read data must be valid in the same cycle as the read strobe. While the select is high, an input chooses the level of the serial output: released (high impedance) or held low.

Top module: `spi_reg_port`

## Requirements
- R1: While the select is high, `miso_oe` equals the inverse of `miso_float_idle` and `miso_d` is 0. While the select is low, `miso_oe` is 1.
- R2: Header bit 7 = 1 selects read and 0 selects write. Bits 5:0 are the start address. Bit 6 has no effect on either.
- R3: In a write, every complete 16 data bits sampled on rising serial clock edges (first bit = bit 15) produce exactly one `reg_wr` pulse, carrying that word on `reg_wdata` and the current address on `reg_addr`.
- R4: After each word's strobe the address increases by one, wrapping from 63 to 0.
- R5: In a read, the word fetched by `reg_rd` appears on `miso_d` bit 15 first. The first bit is driven after the falling edge that follows the header's last rising edge. Each later bit is driven after the next falling edge.
- R6: A read transaction with N complete words issues N+1 `reg_rd` pulses: one after the header and one at the end of every word, which prefetches the next address.
- R7: If the select rises partway through a write word, that partial word produces no `reg_wr`, and the register keeps its old value.
- R8: A write transaction issues no `reg_rd`, a read transaction issues no `reg_wr`, and `miso_d` stays 0 during the header and throughout a write.
- R9: After reset, `reg_wr` and `reg_rd` are 0 and the output follows the idle rule of R1.
- R10: A falling select always restarts header alignment, so a transaction that follows an aborted one decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from host, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_csn | input | 1 | Active-low transaction select |
| miso_float_idle | input | 1 | 1: release output when idle; 0: drive it low |
| miso_d | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the serial data pin |
| reg_addr | output | 6 | Register address |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data, valid in the cycle of `reg_rd` |

## Verification
The bench first writes a distinct, arithmetically derived word to every one of the 64 addresses, toggling the ignored header bit as it goes. It then reads every address back. This sweep separates address decode errors, bit-order errors and direction-flag errors from one another. Multi-word writes and reads that start at addresses 62 and 63 show whether the address steps after each word and wraps at the top. Transactions cut short in the middle of a word show that partial words are dropped and that the next header still aligns. Switching the idle-level input between its two settings shows both output behaviours.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    localparam int AW     = 6;
    localparam int DW     = 16;
    localparam int HW     = 8;
    localparam int CNT_W  = $clog2(DW);

    localparam int IX_SCK  = 0;
    localparam int IX_MOSI = 1;
    localparam int IX_CSN  = 2;
    localparam int NSYNC   = 3;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HDR,
        PH_DATA
    } phase_t;

    typedef struct packed {
        logic          rd;
        logic [AW-1:0] addr;
    } hdr_t;

    function automatic hdr_t decode_hdr(input logic [HW-1:0] b);
        hdr_t h;
        h.rd   = b[HW-1];
        h.addr = b[AW-1:0];
        return h;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) st[0] <= RST_VAL;
        else     st[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) st[i] <= RST_VAL;
            else     st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
    import spi_reg_pkg::*;
#(
    parameter int A_W = AW,
    parameter int D_W = DW,
    parameter int H_W = HW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sck_s,
    input  logic           mosi_s,
    input  logic           csn_s,
    input  logic [D_W-1:0] reg_rdata,
    output logic           reg_wr,
    output logic           reg_rd,
    output logic [A_W-1:0] reg_addr,
    output logic [D_W-1:0] reg_wdata,
    output logic           cs_act,
    output logic           tx_bit
);
    localparam int C_W = $clog2(D_W);

    phase_t         phase;
    logic [C_W-1:0] cnt;
    logic [H_W-1:0] hsr;
    logic [D_W-1:0] rsr;
    logic [D_W-1:0] tsr;
    logic           is_read;
    logic           sck_q;
    logic           csn_q;

    logic           sck_rise, sck_fall, cs_start;
    logic [H_W-1:0] hdr_next;
    logic [D_W-1:0] word_next;
    hdr_t           hdr_dec;

    always_comb begin
        sck_rise  = sck_s & ~sck_q;
        sck_fall  = ~sck_s & sck_q;
        cs_act    = ~csn_s;
        cs_start  = ~csn_s & csn_q;
        hdr_next  = {hsr[H_W-2:0], mosi_s};
        word_next = {rsr[D_W-2:0], mosi_s};
        hdr_dec   = decode_hdr(hdr_next);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            hsr       <= '0;
            rsr       <= '0;
            tsr       <= '0;
            is_read   <= 1'b0;
            sck_q     <= 1'b0;
            csn_q     <= 1'b1;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            tx_bit    <= 1'b0;
        end else begin
            sck_q  <= sck_s;
            csn_q  <= csn_s;
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (reg_wr || reg_rd) reg_addr <= reg_addr + 1'b1;
            if (reg_rd) tsr <= reg_rdata;

            if (!cs_act) begin
                phase  <= PH_IDLE;
                cnt    <= '0;
                tx_bit <= 1'b0;
            end else if (cs_start) begin
                phase  <= PH_HDR;
                cnt    <= '0;
                tx_bit <= 1'b0;
            end else if (sck_rise) begin
                case (phase)
                    PH_HDR: begin
                        hsr <= hdr_next;
                        if (cnt == C_W'(H_W - 1)) begin
                            phase    <= PH_DATA;
                            cnt      <= '0;
                            is_read  <= hdr_dec.rd;
                            reg_addr <= hdr_dec.addr;
                            reg_rd   <= hdr_dec.rd;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        rsr <= word_next;
                        cnt <= cnt + 1'b1;
                        if (cnt == C_W'(D_W - 1)) begin
                            if (is_read) begin
                                reg_rd <= 1'b1;
                            end else begin
                                reg_wr    <= 1'b1;
                                reg_wdata <= word_next;
                            end
                        end
                    end
                    default: ;
                endcase
            end else if (sck_fall && phase == PH_DATA && is_read) begin
                tx_bit <= tsr[D_W-1];
                tsr    <= {tsr[D_W-2:0], 1'b0};
            end
        end
    end

    AST_DIR_EXCL: assert property (@(posedge clk) disable iff (rst)
        (reg_wr |-> !is_read) and (reg_rd |-> !reg_wr)); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (reg_wr || reg_rd) |=> (reg_addr == $past(reg_addr) + 1'b1)); // R4

    AST_WR_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> $past(sck_rise)); // R3

    AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (cs_act && $past(cs_act) && tx_bit != $past(tx_bit)) |-> $past(sck_fall)); // R5

endmodule

// File: rtl/spi_miso_drv.sv
module spi_miso_drv (
    input  logic clk,
    input  logic rst,
    input  logic cs_act,
    input  logic tx_bit,
    input  logic float_idle,
    output logic miso_d,
    output logic miso_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            miso_d  <= 1'b0;
            miso_oe <= 1'b0;
        end else if (cs_act) begin
            miso_d  <= tx_bit;
            miso_oe <= 1'b1;
        end else begin
            miso_d  <= 1'b0;
            miso_oe <= ~float_idle;
        end
    end

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (miso_oe == !$past(float_idle)) && !miso_d); // R1

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
    import spi_reg_pkg::*;
#(
    parameter int A_W     = AW,
    parameter int D_W     = DW,
    parameter int H_W     = HW,
    parameter int STAGES  = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           spi_sck,
    input  logic           spi_mosi,
    input  logic           spi_csn,
    input  logic           miso_float_idle,
    output logic           miso_d,
    output logic           miso_oe,
    output logic [A_W-1:0] reg_addr,
    output logic           reg_wr,
    output logic           reg_rd,
    output logic [D_W-1:0] reg_wdata,
    input  logic [D_W-1:0] reg_rdata
);
    localparam logic [NSYNC-1:0] SYNC_RST = NSYNC'(1) << IX_CSN;

    logic [NSYNC-1:0] raw, synced;
    logic             cs_act, tx_bit;

    always_comb begin
        raw          = '0;
        raw[IX_SCK]  = spi_sck;
        raw[IX_MOSI] = spi_mosi;
        raw[IX_CSN]  = spi_csn;
    end

    spi_sync #(.W(NSYNC), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    spi_reg_ctrl #(.A_W(A_W), .D_W(D_W), .H_W(H_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sck_s     (synced[IX_SCK]),
        .mosi_s    (synced[IX_MOSI]),
        .csn_s     (synced[IX_CSN]),
        .reg_rdata (reg_rdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cs_act    (cs_act),
        .tx_bit    (tx_bit)
    );

    spi_miso_drv u_drv (
        .clk        (clk),
        .rst        (rst),
        .cs_act     (cs_act),
        .tx_bit     (tx_bit),
        .float_idle (miso_float_idle),
        .miso_d     (miso_d),
        .miso_oe    (miso_oe)
    );
endmodule

// File: tb/spi_reg_port_test.sv
`timescale 1ns/1ps
module spi_reg_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0, mosi = 1'b0, csn = 1'b1, float_idle = 1'b1;
    logic        miso_d, miso_oe, reg_wr, reg_rd;
    logic [5:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic [15:0] mem [64];
    logic [15:0] tx_words [4];
    logic [15:0] rx_words [4];
    int          checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0;
    bit          miso_hi, done = 0;

    always #4 clk = ~clk;

    spi_reg_port uut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_mosi(mosi), .spi_csn(csn),
        .miso_float_idle(float_idle), .miso_d(miso_d), .miso_oe(miso_oe),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt = wr_cnt + 1;
        end
        if (reg_rd) rd_cnt = rd_cnt + 1;
    end

    function automatic logic [15:0] pat(input logic [5:0] a, input logic [15:0] s);
        return ({10'd0, a} * 16'h0421) ^ s;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic spi_txn(input logic [7:0] hdr, input int nbits);
        miso_hi = 0;
        @(negedge clk);
        csn = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            logic b;
            int   w, k;
            w = (i - 8) / 16;
            k = 15 - ((i - 8) % 16);
            if (i < 8) b = hdr[3'(7 - i)];
            else       b = tx_words[2'(w)][4'(k)];
            mosi = b;
            repeat (8) @(negedge clk);
            if (i >= 8) rx_words[2'(w)][4'(k)] = miso_d;
            if ((i < 8 || !hdr[7]) && miso_d) miso_hi = 1;
            sck = 1'b1;
            repeat (8) @(negedge clk);
            sck = 1'b0;
        end
        repeat (8) @(negedge clk);
        csn = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %h expected %h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w0, r0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        // R9 reset state, R1 floating idle
        chk(!reg_wr && !reg_rd, "R9", {30'd0, reg_wr, reg_rd}, 0);
        chk(miso_oe == 1'b0 && miso_d == 1'b0, "R9/R1", {30'd0, miso_oe, miso_d}, 0);

        // R1 driven-low idle
        float_idle = 1'b0;
        repeat (6) @(negedge clk);
        chk(miso_oe == 1'b1 && miso_d == 1'b0, "R1", {30'd0, miso_oe, miso_d}, 2);
        float_idle = 1'b1;
        repeat (6) @(negedge clk);
        chk(miso_oe == 1'b0, "R1", {31'd0, miso_oe}, 0);

        // R3/R2/R8: write every address, bit 6 toggled
        for (int a = 0; a < 64; a++) begin
            logic [5:0] ad;
            ad = 6'(a);
            tx_words[0] = pat(ad, 16'h5A3C);
            w0 = wr_cnt; r0 = rd_cnt;
            spi_txn({1'b0, ad[0], ad}, 24);
            chk(wr_cnt - w0 == 1, "R3", 32'(wr_cnt - w0), 1);
            chk(mem[ad] == pat(ad, 16'h5A3C), "R3/R2", {16'd0, mem[ad]}, {16'd0, pat(ad, 16'h5A3C)});
            chk(rd_cnt == r0 && !miso_hi, "R8", 32'(rd_cnt - r0), 0);
        end

        // R5/R2/R6/R8: read every address back
        for (int a = 0; a < 64; a++) begin
            logic [5:0] ad;
            ad = 6'(a);
            w0 = wr_cnt; r0 = rd_cnt;
            spi_txn({1'b1, ad[1], ad}, 24);
            chk(rx_words[0] == pat(ad, 16'h5A3C), "R5/R2", {16'd0, rx_words[0]}, {16'd0, pat(ad, 16'h5A3C)});
            chk(rd_cnt - r0 == 2, "R6", 32'(rd_cnt - r0), 2);
            chk(wr_cnt == w0 && !miso_hi, "R8", 32'(wr_cnt - w0), 0);
        end

        // R4: multi-word write wrapping 62 -> 63 -> 0
        tx_words[0] = 16'hC001; tx_words[1] = 16'h8E17; tx_words[2] = 16'h0FF0;
        w0 = wr_cnt;
        spi_txn(8'h3E, 8 + 48);
        chk(wr_cnt - w0 == 3, "R3", 32'(wr_cnt - w0), 3);
        chk(mem[62] == 16'hC001, "R4", {16'd0, mem[62]}, 32'hC001);
        chk(mem[63] == 16'h8E17, "R4", {16'd0, mem[63]}, 32'h8E17);
        chk(mem[0] == 16'h0FF0, "R4", {16'd0, mem[0]}, 32'h0FF0);

        // R4/R6: multi-word read wrapping 63 -> 0
        r0 = rd_cnt;
        spi_txn(8'hBF, 8 + 32);
        chk(rx_words[0] == 16'h8E17, "R4", {16'd0, rx_words[0]}, 32'h8E17);
        chk(rx_words[1] == 16'h0FF0, "R4", {16'd0, rx_words[1]}, 32'h0FF0);
        chk(rd_cnt - r0 == 3, "R6", 32'(rd_cnt - r0), 3);

        // R7: write aborted after 10 data bits
        tx_words[0] = 16'hDEAD;
        w0 = wr_cnt;
        spi_txn(8'h05, 8 + 10);
        chk(wr_cnt == w0, "R7", 32'(wr_cnt - w0), 0);
        // R10: next read aligns and shows the old value
        spi_txn(8'h85, 24);
        chk(rx_words[0] == pat(6'd5, 16'h5A3C), "R7/R10", {16'd0, rx_words[0]}, {16'd0, pat(6'd5, 16'h5A3C)});

        // R10: read aborted mid-word, then a full write
        spi_txn(8'h89, 8 + 5);
        tx_words[0] = 16'h1234;
        w0 = wr_cnt;
        spi_txn(8'h09, 24);
        chk(wr_cnt - w0 == 1 && mem[9] == 16'h1234, "R10", {16'd0, mem[9]}, 32'h1234);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule